// File: doc/BRIEF.md
# Strided Row Request Sequencer

This block turns one copy descriptor into a series of contiguous row requests for a downstream data mover. A descriptor names a 64-bit source address, a 64-bit destination address, a byte count per row, a source stride, a destination stride, a repeat count, a two-bit configuration field and a transfer tag. The sequencer issues one request per row, made of source address, destination address and length, on a valid/ready channel. Between rows the source and destination addresses each move forward by their own stride.

Configuration bit 1 selects the mode. When the bit is clear the descriptor describes one flat row, and the strides and the repeat count are ignored. When the bit is set the descriptor describes a two-dimensional block whose row count is the repeat count. After the final row has been handed off, the block pulses a completion strobe carrying the descriptor's tag, so that a completed-tag status can be updated. Only one descriptor is in flight at a time.

Top module: `dma_row_sequencer`

## Requirements
- R1: After reset `desc_ready_o` is 1, and `row_valid_o` and `done_o` are 0.
- R2: A descriptor is taken on a clock edge where `desc_valid_i` and `desc_ready_o` are both 1. `desc_ready_o` stays 0 from that acceptance until the last row of that descriptor has been handed off.
- R3: In the cycle after a descriptor that has at least one row is accepted, `row_valid_o` is 1 and the row fields equal the descriptor's source address, destination address and length.
- R4: When `desc_cfg_i[1]` is 0, exactly one row is issued. The stride inputs and the repeat count have no effect on that row.
- R5: When `desc_cfg_i[1]` is 1, exactly `desc_reps_i` rows are issued, and all of them carry the same length.
- R6: Row k has source address `src + k*src_stride` and destination address `dst + k*dst_stride`. The two strides are independent, zero-extended 32-bit values, and every sum wraps modulo 2^64.
- R7: While `row_valid_o` is 1 and `row_ready_i` is 0, the row fields and `row_valid_o` keep their values into the next cycle.
- R8: `done_o` is a one-cycle pulse in the cycle after the last row handshake, with `done_id_o` equal to the descriptor's tag. It is never raised at any other time, except as described in R9.
- R9: In 2D mode with a repeat count of 0, no row is issued and `done_o` pulses in the cycle after acceptance with the descriptor's tag.
- R10: In a cycle where `done_o` is 1, `desc_ready_o` is 1, so that a waiting descriptor is taken without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| desc_valid_i | input | 1 | Descriptor offered |
| desc_ready_o | output | 1 | Sequencer idle and able to take a descriptor |
| desc_src_i | input | 64 | First source address |
| desc_dst_i | input | 64 | First destination address |
| desc_len_i | input | 32 | Bytes per row |
| desc_src_stride_i | input | 32 | Source advance between rows |
| desc_dst_stride_i | input | 32 | Destination advance between rows |
| desc_reps_i | input | 32 | Row count in 2D mode |
| desc_cfg_i | input | 2 | Configuration; bit 1 selects 2D mode |
| desc_id_i | input | 8 | Transfer tag |
| row_valid_o | output | 1 | Row request valid |
| row_ready_i | input | 1 | Downstream takes the row request |
| row_src_o | output | 64 | Row source address |
| row_dst_o | output | 64 | Row destination address |
| row_len_o | output | 32 | Row length in bytes |
| done_o | output | 1 | Completion pulse |
| done_id_o | output | 8 | Tag of the completed descriptor |

## Verification
The embedded assertions check, on every cycle, the properties that can be stated locally. They cover the held row under backpressure, the first row mirroring the accepted descriptor, the per-row source step, the completion strobe having a legal cause, the row counter being empty whenever the block is idle, and the counter never being decremented below zero. Other properties need a scenario and a scoreboard. These are the exact number of rows per mode, the disregarded strides and repeat count in 1D mode, address wrap past 2^64, the immediate completion for a zero repeat count, the tag order and the acceptance of a descriptor in the completion cycle. The bench drives these cases with both steady and irregular downstream readiness.

// File: rtl/dma_row_pkg.sv
package dma_row_pkg;

    parameter int unsigned ADDR_W  = 64;
    parameter int unsigned LEN_W   = 32;
    parameter int unsigned STRD_W  = 32;
    parameter int unsigned CNT_W   = 32;
    parameter int unsigned TAG_W   = 8;
    parameter int unsigned CFG_W   = 2;
    parameter int unsigned CFG_2D  = 1;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/dma_row_addr_step.sv
module dma_row_addr_step #(
    parameter int unsigned AW        = 64,
    parameter int unsigned SW        = 32,
    parameter bit          SIGNED_ST = 1'b0
) (
    input  logic [AW-1:0] base_i,
    input  logic [SW-1:0] stride_i,
    output logic [AW-1:0] next_o
);

    localparam int unsigned EXT_W = AW - SW;

    logic [AW-1:0] stride_ext;

    generate
        if (SIGNED_ST) begin : g_sext
            assign stride_ext = {{EXT_W{stride_i[SW-1]}}, stride_i};
        end else begin : g_zext
            assign stride_ext = {{EXT_W{1'b0}}, stride_i};
        end
    endgenerate

    // Modular sum: any carry out of the top bit is dropped.
    assign next_o = base_i + stride_ext;

endmodule

// File: rtl/dma_row_counter.sv
module dma_row_counter #(
    parameter int unsigned CW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          dec_i,
    output logic [CW-1:0] count_o,
    output logic          last_o
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (load_i) begin
            count_d = load_val_i;
        end else if (dec_i) begin
            count_d = count_q - ONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count_o = count_q;
    assign last_o  = (count_q == ONE);

    // R5: the row count is never taken below zero
    a_r5_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dec_i |-> (count_q != '0));

endmodule

// File: rtl/dma_row_sequencer.sv
module dma_row_sequencer
    import dma_row_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned LW = LEN_W,
    parameter int unsigned SW = STRD_W,
    parameter int unsigned CW = CNT_W,
    parameter int unsigned TW = TAG_W,
    parameter int unsigned FW = CFG_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          desc_valid_i,
    output logic          desc_ready_o,
    input  logic [AW-1:0] desc_src_i,
    input  logic [AW-1:0] desc_dst_i,
    input  logic [LW-1:0] desc_len_i,
    input  logic [SW-1:0] desc_src_stride_i,
    input  logic [SW-1:0] desc_dst_stride_i,
    input  logic [CW-1:0] desc_reps_i,
    input  logic [FW-1:0] desc_cfg_i,
    input  logic [TW-1:0] desc_id_i,
    output logic          row_valid_o,
    input  logic          row_ready_i,
    output logic [AW-1:0] row_src_o,
    output logic [AW-1:0] row_dst_o,
    output logic [LW-1:0] row_len_o,
    output logic          done_o,
    output logic [TW-1:0] done_id_o
);

    localparam logic [CW-1:0] ONE_ROW = CW'(1);

    typedef struct packed {
        seq_state_e    state;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [LW-1:0] len;
        logic [SW-1:0] src_st;
        logic [SW-1:0] dst_st;
        logic [TW-1:0] tag;
        logic          done;
        logic [TW-1:0] done_tag;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic          accept;
    logic          mode_2d;
    logic [CW-1:0] row_total;
    logic          no_rows;
    logic          row_hs;
    logic          cnt_last;
    logic [CW-1:0] cnt_rem;
    logic [AW-1:0] src_next;
    logic [AW-1:0] dst_next;

    assign desc_ready_o = (r_q.state == SEQ_IDLE);
    assign accept       = desc_valid_i && desc_ready_o;
    assign mode_2d      = desc_cfg_i[CFG_2D];
    assign row_total    = mode_2d ? desc_reps_i : ONE_ROW;
    assign no_rows      = (row_total == '0);
    assign row_valid_o  = (r_q.state == SEQ_RUN);
    assign row_hs       = row_valid_o && row_ready_i;

    dma_row_addr_step #(.AW(AW), .SW(SW), .SIGNED_ST(1'b0)) u_src_step (
        .base_i   (r_q.src),
        .stride_i (r_q.src_st),
        .next_o   (src_next)
    );

    dma_row_addr_step #(.AW(AW), .SW(SW), .SIGNED_ST(1'b0)) u_dst_step (
        .base_i   (r_q.dst),
        .stride_i (r_q.dst_st),
        .next_o   (dst_next)
    );

    dma_row_counter #(.CW(CW)) u_rows (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (accept),
        .load_val_i (row_total),
        .dec_i      (row_hs),
        .count_o    (cnt_rem),
        .last_o     (cnt_last)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            SEQ_IDLE: begin
                if (accept) begin
                    r_d.src    = desc_src_i;
                    r_d.dst    = desc_dst_i;
                    r_d.len    = desc_len_i;
                    r_d.src_st = desc_src_stride_i;
                    r_d.dst_st = desc_dst_stride_i;
                    r_d.tag    = desc_id_i;
                    if (no_rows) begin
                        r_d.done     = 1'b1;
                        r_d.done_tag = desc_id_i;
                    end else begin
                        r_d.state = SEQ_RUN;
                    end
                end
            end
            SEQ_RUN: begin
                if (row_hs) begin
                    if (cnt_last) begin
                        r_d.state    = SEQ_IDLE;
                        r_d.done     = 1'b1;
                        r_d.done_tag = r_q.tag;
                    end else begin
                        r_d.src = src_next;
                        r_d.dst = dst_next;
                    end
                end
            end
            default: r_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{state: SEQ_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign row_src_o = r_q.src;
    assign row_dst_o = r_q.dst;
    assign row_len_o = r_q.len;
    assign done_o    = r_q.done;
    assign done_id_o = r_q.done_tag;

    // R2: whenever a new descriptor could be taken, no rows remain outstanding
    a_r2_idle_no_rows_left: assert property (@(posedge clk_i) disable iff (!rst_ni)
        desc_ready_o |-> (cnt_rem == '0));

    // R3: the first row mirrors the accepted descriptor
    a_r3_first_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept && !no_rows) |=> (row_valid_o
            && row_src_o == $past(desc_src_i)
            && row_dst_o == $past(desc_dst_i)
            && row_len_o == $past(desc_len_i)));

    // R6: source moves by its own stride after a non-final row
    a_r6_src_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (row_hs && !cnt_last) |=> (row_src_o == $past(row_src_o) + AW'($past(r_q.src_st))));

    // R7: a stalled row request is held unchanged
    a_r7_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (row_valid_o && !row_ready_i) |=> (row_valid_o && $stable(row_src_o)
            && $stable(row_dst_o) && $stable(row_len_o)));

    // R8, R9: completion only follows a final handshake or an empty descriptor
    a_r8_done_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ($past(row_hs && cnt_last) || $past(accept && no_rows)));

endmodule

// File: tb/dma_row_sequencer_test.sv
module dma_row_sequencer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        desc_valid = 1'b0;
    logic        desc_ready;
    logic [63:0] desc_src = '0, desc_dst = '0;
    logic [31:0] desc_len = '0, desc_ss = '0, desc_ds = '0, desc_reps = '0;
    logic [1:0]  desc_cfg = '0;
    logic [7:0]  desc_id = '0;
    logic        row_valid, row_ready = 1'b0;
    logic [63:0] row_src, row_dst;
    logic [31:0] row_len;
    logic        done;
    logic [7:0]  done_id;

    always #4 clk = ~clk;

    dma_row_sequencer uut (
        .clk_i(clk), .rst_ni(rst_n),
        .desc_valid_i(desc_valid), .desc_ready_o(desc_ready),
        .desc_src_i(desc_src), .desc_dst_i(desc_dst), .desc_len_i(desc_len),
        .desc_src_stride_i(desc_ss), .desc_dst_stride_i(desc_ds),
        .desc_reps_i(desc_reps), .desc_cfg_i(desc_cfg), .desc_id_i(desc_id),
        .row_valid_o(row_valid), .row_ready_i(row_ready),
        .row_src_o(row_src), .row_dst_o(row_dst), .row_len_o(row_len),
        .done_o(done), .done_id_o(done_id)
    );

    typedef struct {
        logic [63:0] src;
        logic [63:0] dst;
        logic [31:0] len;
        bit          last;
    } row_t;

    row_t       rows_q[$];
    logic [7:0] ids_q[$];
    int  n_chk = 0;
    int  n_bad = 0;
    bit  zero_expect = 0;
    bit  ready_rand = 0;
    bit  finished = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // downstream readiness, changed just after the rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            row_ready = ready_rand ? lfsr[0] : 1'b1;
        end
    end

    // driver: offers a descriptor and records what it must produce
    task automatic send(input logic [63:0] s, input logic [63:0] d, input logic [31:0] len,
                        input logic [31:0] ss, input logic [31:0] ds, input logic [31:0] reps,
                        input logic [1:0] cfg, input logic [7:0] id);
        logic [63:0] sa, da;
        int unsigned n;
        @(negedge clk);
        desc_src = s; desc_dst = d; desc_len = len; desc_ss = ss; desc_ds = ds;
        desc_reps = reps; desc_cfg = cfg; desc_id = id; desc_valid = 1'b1;
        while (!desc_ready) @(negedge clk);
        @(posedge clk);
        n  = cfg[1] ? reps : 1;
        sa = s;
        da = d;
        for (int unsigned k = 0; k < n; k++) begin
            rows_q.push_back('{src: sa, dst: da, len: len, last: (k == n - 1)});
            sa = sa + {32'h0, ss};
            da = da + {32'h0, ds};
        end
        ids_q.push_back(id);
        if (n == 0) zero_expect = 1;
        #1 desc_valid = 1'b0;
    endtask

    // monitor: compares produced rows and completions with the scoreboard
    initial begin
        bit          exp_done_next = 0;
        bit          stalled = 0;
        logic [63:0] h_src, h_dst;
        logic [31:0] h_len;
        row_t        e;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                // R8 R9: completion exactly when due
                check(done == (exp_done_next || zero_expect), "R8/R9", "done timing",
                      64'(done), 64'(exp_done_next || zero_expect));
                if (done) begin
                    if (ids_q.size() == 0) begin
                        check(0, "R8", "done with no pending tag", 64'(done_id), 64'h0);
                    end else begin
                        check(done_id == ids_q[0], "R8", "done tag", 64'(done_id), 64'(ids_q[0]));
                        void'(ids_q.pop_front());
                    end
                    check(rows_q.size() == 0, "R8", "rows left at done", 64'(rows_q.size()), 64'h0);
                    check(desc_ready == 1'b1, "R10", "ready in done cycle", 64'(desc_ready), 64'h1);
                end
                zero_expect   = 0;
                exp_done_next = 0;
                if (row_valid && desc_ready)
                    check(0, "R2", "ready while rows pending", 64'(desc_ready), 64'h0);
                if (row_valid) begin
                    if (stalled) begin
                        check(row_src == h_src && row_dst == h_dst && row_len == h_len,
                              "R7", "held row", row_src, h_src);
                    end
                    if (row_ready) begin
                        if (rows_q.size() == 0) begin
                            check(0, "R4/R5", "unexpected row", row_src, 64'h0);
                        end else begin
                            e = rows_q.pop_front();
                            check(row_src == e.src, "R6", "row source", row_src, e.src);
                            check(row_dst == e.dst, "R6", "row destination", row_dst, e.dst);
                            check(row_len == e.len, "R5", "row length", 64'(row_len), 64'(e.len));
                            if (e.last) exp_done_next = 1;
                        end
                    end
                    stalled = !row_ready;
                    h_src = row_src; h_dst = row_dst; h_len = row_len;
                end else begin
                    stalled = 0;
                end
            end
        end
    end

    task automatic drain();
        int guard = 0;
        while ((rows_q.size() != 0 || ids_q.size() != 0 || !desc_ready) && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
        check(rows_q.size() == 0 && ids_q.size() == 0, "R4/R5", "scoreboard drained",
              64'(rows_q.size()), 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(desc_ready == 1'b1, "R1", "ready in reset", 64'(desc_ready), 64'h1);
        check(row_valid == 1'b0, "R1", "row valid in reset", 64'(row_valid), 64'h0);
        check(done == 1'b0, "R1", "done in reset", 64'(done), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(desc_ready == 1'b1 && row_valid == 1'b0 && done == 1'b0, "R1",
              "idle after reset", {61'h0, desc_ready, row_valid, done}, 64'h4);

        // R4: 1D with strides and repeat set, one row only
        send(64'h0000_0001_0000_1000, 64'h0000_0002_0000_2000, 32'd64,
             32'h100, 32'h200, 32'd5, 2'b00, 8'h11);
        drain();
        // R4: bit 0 alone does not select 2D
        send(64'h3000, 64'h4000, 32'd16, 32'h40, 32'h80, 32'd7, 2'b01, 8'h12);
        drain();
        // R5 R6: 2D with distinct strides
        send(64'h0000_0000_0001_0000, 64'h0000_00FF_0000_0000, 32'd32,
             32'h40, 32'h1000, 32'd4, 2'b10, 8'h21);
        drain();
        // R9: 2D with zero repeat
        send(64'h5000, 64'h6000, 32'd8, 32'h10, 32'h10, 32'd0, 2'b10, 8'h30);
        drain();
        // R6: wrap past 2^64, irregular readiness for R7
        ready_rand = 1;
        send(64'hFFFF_FFFF_FFFF_FFF0, 64'hFFFF_FFFF_FFFF_FF00, 32'd4,
             32'h20, 32'h90, 32'd3, 2'b11, 8'h41);
        send(64'h7000, 64'h8000, 32'd128, 32'h0, 32'h400, 32'd6, 2'b10, 8'h42);
        drain();
        // R10: back-to-back descriptors, including empty ones
        send(64'h9000, 64'hA000, 32'd12, 32'h8, 32'h18, 32'd2, 2'b10, 8'h51);
        send(64'hB000, 64'hC000, 32'd20, 32'h4, 32'h4, 32'd0, 2'b10, 8'h52);
        send(64'hD000, 64'hE000, 32'd24, 32'h0, 32'h0, 32'd0, 2'b10, 8'h53);
        send(64'hF000, 64'h1_0000, 32'd40, 32'h30, 32'h60, 32'd1, 2'b00, 8'h54);
        drain();
        ready_rand = 0;
        send(64'h2_0000, 64'h3_0000, 32'd1, 32'h1, 32'h2, 32'd3, 2'b10, 8'h61);
        send(64'h4_0000, 64'h5_0000, 32'd2, 32'h3, 32'h5, 32'd2, 2'b10, 8'h62);
        drain();
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule